// File: doc/BRIEF.md
# Power-Cut Wake-Up Sequencer

This block is a small controller that runs from the 32 kHz slow clock. It handles entry into a power-cut state and the wake-up from it. Software first sets a 2-bit warm-up select and a power-enable control bit while the arm bit is clear. It then writes the arm bit with those fields left unchanged, and the block enters the power-cut state. In that state the internal reset is held low. If the control bit is set, the external power-enable pin is also driven low.

A synchronised wake-up request raises the power-enable pin again. The block then counts out the selected warm-up time, waits one more slow-clock period, and releases the internal reset. A status flag lets the boot code tell a power-cut restart from a cold start.

A second function copies a parameterised set of source registers into a backup store. The copies are chosen by a mask, and a done vector reports which copies have finished. A power cut keeps the backup contents, and only a cold reset clears them.

Top module: `pcm_wake_seq`

## Requirements
- R1: After cold reset (rst_n low) the outputs read: ctrl_arm=0, ctrl_pwe=0, ctrl_wusel=0, arm_err=0, wake_pend=0, wake_flag=0, pwr_en=1, int_rst_n=1, bkp_mask=0, bkp_done=0.
- R2: A control write (wr_addr=0) whose wr_data bit 0 (arm) is 1 while bit 1 (power-enable) or bits 3:2 (warm-up select) differ from the stored values is ignored entirely, and the sticky arm_err bit is set.
- R3: A control write with wr_data bit 0 = 0, made in normal mode, stores bit 1 into ctrl_pwe and bits 3:2 into ctrl_wusel.
- R4: A synchronised wake_req sets wake_pend, and wake_clr clears it. An arm write made while wake_pend=1 is refused: ctrl_arm stays 0 and int_rst_n stays 1.
- R5: An accepted arm write sets ctrl_arm. int_rst_n goes low within two cycles. pwr_en goes low if ctrl_pwe=1 and stays 1 if ctrl_pwe=0.
- R6: In the power-cut state, with wake_req first sampled high on rising edge A, pwr_en is still 0 after edge A+2 and reads 1 after edge A+3.
- R7: int_rst_n is 0 after edge A+N+2 and 1 after edge A+N+3, where N = 512 << ctrl_wusel slow-clock cycles (15.625 ms to 125 ms at 32.768 kHz).
- R8: When the reset is released after a wake-up, wake_flag reads 1, ctrl_arm reads 0, and bkp_data and bkp_done keep their values.
- R9: A mask write (wr_addr=1, wr_data[NREG-1:0]) loads bkp_mask and clears the done bits that the new mask selects. Done bits outside the new mask are kept. Each later cycle copies the lowest selected register that is not yet done and sets its done bit. A register whose copy is done does not follow later changes of its source.
- R10: While the block is not in normal mode, control and mask writes are ignored.
- R11: A wake_req in normal mode only sets wake_pend. pwr_en and int_rst_n stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Cold system reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = backup mask |
| wr_data | input | DW | Write data |
| wake_req | input | 1 | Asynchronous wake-up request |
| wake_clr | input | 1 | Clears the latched wake-up request |
| src_regs | input | NREG*RW | Registers offered for backup, register i in bits i*RW upward |
| ctrl_arm | output | 1 | Arm bit |
| ctrl_pwe | output | 1 | Power-enable control bit |
| ctrl_wusel | output | 2 | Warm-up select |
| arm_err | output | 1 | Sticky flag for a rejected arm write |
| wake_pend | output | 1 | Latched wake-up request |
| wake_flag | output | 1 | 1 when the restart came from power-cut wake-up |
| pwr_en | output | 1 | External power-enable pin |
| int_rst_n | output | 1 | Internal reset to the core, active low |
| bkp_mask | output | NREG | Backup copy mask |
| bkp_done | output | NREG | Completed copies |
| bkp_data | output | NREG*RW | Backup store |

## Verification
The bench counts edges around the wake-up. A pwr_en that rises one edge early or late is caught, and so is a reset release that drops the extra period after warm-up or ends the count one cycle short. It tries an arm write with changed fields, which a design checking only the arm bit would accept, and an arm write with a request still pending, which a design without the pending gate would take into power cut. The backup test changes the sources after their copies finish, so a store that keeps copying shows the new values. It also re-masks a single bit, so clearing every done bit on a mask write shows up. A power cut with the control bit clear checks that pwr_en is left high.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
   typedef enum logic [2:0] {
      ST_NORMAL  = 3'd0,
      ST_ARMED   = 3'd1,
      ST_CUT     = 3'd2,
      ST_WARMUP  = 3'd3,
      ST_RELEASE = 3'd4
   } pcm_state_e;

   localparam int CTL_ARM_BIT = 0;
   localparam int CTL_PWE_BIT = 1;
   localparam int CTL_SEL_LSB = 2;
   localparam int CTL_WIDTH   = 4;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pcm_seq.sv
module pcm_seq
   import pcm_pkg::*;
#(
   parameter int WU_BASE = 512
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [CTL_WIDTH-1:0] ctl_wdata,
   input  logic                 req_s,
   input  logic                 wake_clr,
   output logic                 arm_q,
   output logic                 pwe_q,
   output logic [1:0]           sel_q,
   output logic                 err_q,
   output logic                 pend_q,
   output logic                 flag_q,
   output logic                 pwr_en_q,
   output logic                 rst_q,
   output logic                 in_normal,
   output logic                 core_on
);
   localparam int CW = $clog2(WU_BASE) + 4;

   if (WU_BASE < 2 || (WU_BASE & (WU_BASE - 1)) != 0) begin : g_bad_base
      $error("pcm_seq: WU_BASE must be a power of two of at least 2");
   end

   pcm_state_e       state, nxt;
   logic [CW-1:0]    cnt, last;
   logic             wr_arm, wr_pwe;
   logic [1:0]       wr_sel;
   logic             viol, arm_try, arm_go, fld_wr;

   assign wr_arm = ctl_wdata[CTL_ARM_BIT];
   assign wr_pwe = ctl_wdata[CTL_PWE_BIT];
   assign wr_sel = ctl_wdata[CTL_SEL_LSB +: 2];

   assign in_normal = (state == ST_NORMAL);
   assign core_on   = (state == ST_NORMAL) || (state == ST_ARMED);

   assign viol    = ctl_we && in_normal && wr_arm && ((wr_pwe != pwe_q) || (wr_sel != sel_q));
   assign arm_try = ctl_we && in_normal && wr_arm && !viol;
   assign arm_go  = arm_try && !pend_q;
   assign fld_wr  = ctl_we && in_normal && !wr_arm;

   assign last = (CW'(WU_BASE) << sel_q) - CW'(1);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_NORMAL:  if (arm_go) nxt = ST_ARMED;
         ST_ARMED:   nxt = ST_CUT;
         ST_CUT:     if (req_s) nxt = ST_WARMUP;
         ST_WARMUP:  if (cnt == last) nxt = ST_RELEASE;
         ST_RELEASE: nxt = ST_NORMAL;
         default:    nxt = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_NORMAL;
         cnt      <= '0;
         arm_q    <= 1'b0;
         pwe_q    <= 1'b0;
         sel_q    <= 2'd0;
         err_q    <= 1'b0;
         pend_q   <= 1'b0;
         flag_q   <= 1'b0;
         pwr_en_q <= 1'b1;
         rst_q    <= 1'b1;
      end else begin
         state <= nxt;
         cnt   <= (state == ST_WARMUP) ? cnt + CW'(1) : '0;
         rst_q <= (nxt == ST_NORMAL) || (nxt == ST_ARMED);
         if (viol) err_q <= 1'b1;
         if (fld_wr) begin
            pwe_q <= wr_pwe;
            sel_q <= wr_sel;
         end
         if (arm_go) arm_q <= 1'b1;
         else if (state == ST_RELEASE) arm_q <= 1'b0;
         if (state == ST_RELEASE) flag_q <= 1'b1;
         if (req_s) pend_q <= 1'b1;
         else if (wake_clr) pend_q <= 1'b0;
         if (state == ST_ARMED && pwe_q) pwr_en_q <= 1'b0;
         else if (state == ST_WARMUP) pwr_en_q <= 1'b1;
      end
   end

   AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> ($stable(pwe_q) && $stable(sel_q) && $stable(arm_q))); // R2
   AST_REFUSE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (in_normal && pend_q && ctl_we && wr_arm) |=> (state == ST_NORMAL)); // R4
   AST_RESET_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CUT || state == ST_WARMUP) |-> !rst_q); // R5
   AST_PWR_ON_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NORMAL) |-> pwr_en_q); // R6
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WARMUP) |-> (cnt <= last)); // R7
   AST_RELEASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> (flag_q && !arm_q)); // R8
   AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_normal) |=> ($stable(pwe_q) && $stable(sel_q))); // R10
endmodule

// File: rtl/pcm_backup.sv
module pcm_backup #(
   parameter int NREG = 4,
   parameter int RW   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mask_we,
   input  logic [NREG-1:0]      mask_wdata,
   input  logic                 copy_en,
   input  logic [NREG*RW-1:0]   src,
   output logic [NREG-1:0]      mask_q,
   output logic [NREG-1:0]      done_q,
   output logic [NREG*RW-1:0]   bkp_q
);
   if (NREG < 1 || RW < 1) begin : g_bad_size
      $error("pcm_backup: NREG and RW must be positive");
   end

   logic [NREG-1:0] todo, pick;
   logic            go;

   assign todo = mask_q & ~done_q;
   assign go   = copy_en && !mask_we;

   always_comb begin
      pick = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (todo[i]) pick = NREG'(1) << i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         done_q <= '0;
      end else if (mask_we) begin
         mask_q <= mask_wdata;
         done_q <= done_q & ~mask_wdata;
      end else if (go) begin
         done_q <= done_q | pick;
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                bkp_q[g*RW +: RW] <= '0;
         else if (go && pick[g])    bkp_q[g*RW +: RW] <= src[g*RW +: RW];
      end
   end

   AST_ONE_COPY_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(done_q & ~$past(done_q)) <= 1); // R9
   AST_COPY_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_q & ~$past(done_q) & ~mask_q) == '0)); // R9
endmodule

// File: rtl/pcm_wake_seq.sv
module pcm_wake_seq
   import pcm_pkg::*;
#(
   parameter int NREG        = 4,
   parameter int RW          = 8,
   parameter int DW          = 8,
   parameter int WU_BASE     = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic                 wake_req,
   input  logic                 wake_clr,
   input  logic [NREG*RW-1:0]   src_regs,
   output logic                 ctrl_arm,
   output logic                 ctrl_pwe,
   output logic [1:0]           ctrl_wusel,
   output logic                 arm_err,
   output logic                 wake_pend,
   output logic                 wake_flag,
   output logic                 pwr_en,
   output logic                 int_rst_n,
   output logic [NREG-1:0]      bkp_mask,
   output logic [NREG-1:0]      bkp_done,
   output logic [NREG*RW-1:0]   bkp_data
);
   if (DW < CTL_WIDTH || DW < NREG) begin : g_bad_dw
      $error("pcm_wake_seq: DW must cover the control fields and the mask");
   end

   logic req_s, in_normal, core_on;

   pcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (wake_req),
      .q_sync  (req_s)
   );

   pcm_seq #(.WU_BASE(WU_BASE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (wr_en && !wr_addr),
      .ctl_wdata (wr_data[CTL_WIDTH-1:0]),
      .req_s     (req_s),
      .wake_clr  (wake_clr),
      .arm_q     (ctrl_arm),
      .pwe_q     (ctrl_pwe),
      .sel_q     (ctrl_wusel),
      .err_q     (arm_err),
      .pend_q    (wake_pend),
      .flag_q    (wake_flag),
      .pwr_en_q  (pwr_en),
      .rst_q     (int_rst_n),
      .in_normal (in_normal),
      .core_on   (core_on)
   );

   pcm_backup #(.NREG(NREG), .RW(RW)) u_bkp (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (wr_en && wr_addr && in_normal),
      .mask_wdata (wr_data[NREG-1:0]),
      .copy_en    (core_on),
      .src        (src_regs),
      .mask_q     (bkp_mask),
      .done_q     (bkp_done),
      .bkp_q      (bkp_data)
   );
endmodule

// File: tb/pcm_wake_seq_bench.sv
module pcm_wake_seq_bench;
   localparam int NREG = 4;
   localparam int RW   = 8;
   localparam int DW   = 8;
   localparam int BASE = 512;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              wr_addr = 1'b0;
   logic [DW-1:0]     wr_data = '0;
   logic              wake_req = 1'b0;
   logic              wake_clr = 1'b0;
   logic [NREG*RW-1:0] src_regs = '0;
   logic              ctrl_arm, ctrl_pwe, arm_err, wake_pend, wake_flag, pwr_en, int_rst_n;
   logic [1:0]        ctrl_wusel;
   logic [NREG-1:0]   bkp_mask, bkp_done;
   logic [NREG*RW-1:0] bkp_data;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   pcm_wake_seq u_pcm_wake_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wake_req(wake_req), .wake_clr(wake_clr), .src_regs(src_regs),
      .ctrl_arm(ctrl_arm), .ctrl_pwe(ctrl_pwe), .ctrl_wusel(ctrl_wusel), .arm_err(arm_err),
      .wake_pend(wake_pend), .wake_flag(wake_flag), .pwr_en(pwr_en), .int_rst_n(int_rst_n),
      .bkp_mask(bkp_mask), .bkp_done(bkp_done), .bkp_data(bkp_data)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic addr, input logic [DW-1:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [DW-1:0] ctl(input logic [1:0] sel, input logic pwe, input logic arm);
      return DW'({sel, pwe, arm});
   endfunction

   task automatic pulse_clr();
      @(negedge clk); wake_clr = 1'b1;
      @(negedge clk); wake_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "ctrl_arm", 32'(ctrl_arm), 0);
      chk("R1", "ctrl_pwe", 32'(ctrl_pwe), 0);
      chk("R1", "ctrl_wusel", 32'(ctrl_wusel), 0);
      chk("R1", "arm_err", 32'(arm_err), 0);
      chk("R1", "wake_pend", 32'(wake_pend), 0);
      chk("R1", "wake_flag", 32'(wake_flag), 0);
      chk("R1", "pwr_en", 32'(pwr_en), 1);
      chk("R1", "int_rst_n", 32'(int_rst_n), 1);
      chk("R1", "bkp_mask", 32'(bkp_mask), 0);
      chk("R1", "bkp_done", 32'(bkp_done), 0);
   endtask

   task automatic t_fields();
      wr(1'b0, ctl(2'd2, 1'b1, 1'b0));
      chk("R3", "ctrl_wusel", 32'(ctrl_wusel), 2);
      chk("R3", "ctrl_pwe", 32'(ctrl_pwe), 1);
      chk("R3", "ctrl_arm", 32'(ctrl_arm), 0);
   endtask

   task automatic t_violation();
      wr(1'b0, ctl(2'd1, 1'b1, 1'b1));
      chk("R2", "arm_err", 32'(arm_err), 1);
      chk("R2", "ctrl_arm", 32'(ctrl_arm), 0);
      chk("R2", "ctrl_wusel", 32'(ctrl_wusel), 2);
      wr(1'b0, ctl(2'd2, 1'b0, 1'b1));
      chk("R2", "ctrl_pwe kept", 32'(ctrl_pwe), 1);
      chk("R2", "ctrl_arm after pwe change", 32'(ctrl_arm), 0);
      chk("R2", "int_rst_n", 32'(int_rst_n), 1);
   endtask

   task automatic t_wake_normal();
      @(negedge clk); wake_req = 1'b1;
      repeat (4) @(negedge clk);
      wake_req = 1'b0;
      chk("R11", "wake_pend", 32'(wake_pend), 1);
      chk("R11", "pwr_en", 32'(pwr_en), 1);
      chk("R11", "int_rst_n", 32'(int_rst_n), 1);
   endtask

   task automatic t_refused();
      wr(1'b0, ctl(2'd2, 1'b1, 1'b1));
      repeat (3) @(negedge clk);
      chk("R4", "ctrl_arm refused", 32'(ctrl_arm), 0);
      chk("R4", "int_rst_n stays high", 32'(int_rst_n), 1);
      pulse_clr();
      chk("R4", "wake_pend cleared", 32'(wake_pend), 0);
   endtask

   task automatic t_backup();
      src_regs = 32'h44332211;
      wr(1'b1, DW'(4'b0101));
      chk("R9", "bkp_mask", 32'(bkp_mask), 4'b0101);
      chk("R9", "done after write", 32'(bkp_done), 0);
      @(negedge clk);
      chk("R9", "done after 1 copy", 32'(bkp_done), 4'b0001);
      @(negedge clk);
      chk("R9", "done after 2 copies", 32'(bkp_done), 4'b0101);
      src_regs = 32'hDDCCBBAA;
      repeat (3) @(negedge clk);
      chk("R9", "backup 0 frozen", 32'(bkp_data[0 +: RW]), 32'h11);
      chk("R9", "backup 2 frozen", 32'(bkp_data[2*RW +: RW]), 32'h33);
      chk("R9", "backup 1 untouched", 32'(bkp_data[RW +: RW]), 0);
      wr(1'b1, DW'(4'b0010));
      chk("R9", "old done kept", 32'(bkp_done), 4'b0101);
      @(negedge clk);
      chk("R9", "done after remask", 32'(bkp_done), 4'b0111);
      chk("R9", "backup 1 copied", 32'(bkp_data[RW +: RW]), 32'hBB);
   endtask

   task automatic t_power_cut(input logic [1:0] code, input logic pwe);
      int n;
      n = BASE << code;
      wr(1'b0, ctl(code, pwe, 1'b0));
      pulse_clr();
      wr(1'b0, ctl(code, pwe, 1'b1));
      chk("R5", "ctrl_arm set", 32'(ctrl_arm), 1);
      repeat (2) @(negedge clk);
      chk("R5", "int_rst_n low", 32'(int_rst_n), 0);
      chk("R5", "pwr_en in cut", 32'(pwr_en), 32'(!pwe));
      wr(1'b0, ctl(~code, ~pwe, 1'b0));
      wr(1'b1, DW'(4'b1000));
      chk("R10", "ctrl_wusel kept", 32'(ctrl_wusel), 32'(code));
      chk("R10", "ctrl_arm kept", 32'(ctrl_arm), 1);
      chk("R10", "bkp_mask kept", 32'(bkp_mask), 4'b0010);
      @(negedge clk); wake_req = 1'b1;
      repeat (3) @(negedge clk);
      if (pwe) chk("R6", "pwr_en after A+2", 32'(pwr_en), 0);
      @(negedge clk);
      wake_req = 1'b0;
      chk("R6", "pwr_en after A+3", 32'(pwr_en), 1);
      repeat (n - 1) @(negedge clk);
      chk("R7", "int_rst_n after A+N+2", 32'(int_rst_n), 0);
      @(negedge clk);
      chk("R7", "int_rst_n after A+N+3", 32'(int_rst_n), 1);
      chk("R8", "wake_flag", 32'(wake_flag), 1);
      chk("R8", "ctrl_arm cleared", 32'(ctrl_arm), 0);
      chk("R8", "bkp_done kept", 32'(bkp_done), 4'b0111);
      chk("R8", "backup 0 kept", 32'(bkp_data[0 +: RW]), 32'h11);
      pulse_clr();
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_fields();
      t_violation();
      t_wake_normal();
      t_refused();
      t_backup();
      t_power_cut(2'd1, 1'b1);
      t_power_cut(2'd0, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule